// File: doc/BRIEF.md
# DAC Channel Sample Source Selector

This block picks the sample stream that feeds one DAC channel. Each clock beat carries two samples: slot 0 in the low half and slot 1 in the high half. In complex mode, slot 0 holds I and slot 1 holds Q. A beat is taken whenever `in_valid` is high.

The candidate sources are:
- a tone-synthesizer beat;
- a fixed pattern built from two programmed words;
- the user (DMA) data;
- a loopback beat;
- an internal PRBS-15 generator.

A 4-bit select field picks the source. Two override controls can force the loopback or PRBS selection; if both are set they cancel each other out.

After selection, an output stage can convert each sample from two's complement to offset binary. In complex mode it can also exchange the I and Q samples. The result is registered and presented one clock after the input beat.

Top module: `dac_src_sel`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_data` is 0. The PRBS register holds 15'h7FFF, so the first PRBS beat after reset carries 16'h7FFF in both slots.
- R2: Select codes with no override active:
  - 4'h0 passes `dds_data`.
  - 4'h1 outputs `{pat_hi, pat_lo}`, with `pat_lo` in slot 0.
  - 4'h2 passes `dma_data`.
  - 4'h8 passes `lb_data`.
  - 4'h9 outputs the PRBS sample.
- R3: Any other select code (3 to 7, 10 to 15) produces an all-zero beat before formatting.
- R4: When `lb_ovr`=1 and `pn_ovr`=0, the effective code is 4'h8 (loopback), whatever `src_sel` holds.
- R5: When `pn_ovr`=1 and `lb_ovr`=0, the effective code is 4'h9 (PRBS), whatever `src_sel` holds.
- R6: When both `lb_ovr` and `pn_ovr` are 1, both are ignored and `src_sel` is used.
- R7: When `fmt_offset`=1, the most significant bit of each 16-bit slot (bits 15 and 31) is inverted. When `fmt_offset`=0, samples pass in two's complement unchanged.
- R8: When `iq_mode`=1 and `iq_swap`=1, slots 0 and 1 are exchanged. `iq_swap` has no effect when `iq_mode`=0.
- R9: The PRBS sample is `{1'b0, s}` in both slots, where s is the 15-bit state.
  - The state steps once per valid beat, whatever source is selected: next state = `{s[13:0], s[14]^s[13]}` (x^15+x^14+1).
  - The state does not change on beats where `in_valid`=0.
- R10: `out_valid` equals `in_valid` delayed by one clock. `out_data` takes the formatted beat one clock after a valid beat and holds its value while `in_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat valid; steps PRBS and loads output |
| src_sel | input | 4 | Programmed source code |
| lb_ovr | input | 1 | Force loopback selection |
| pn_ovr | input | 1 | Force PRBS selection |
| fmt_offset | input | 1 | 1 = offset binary, 0 = two's complement |
| iq_mode | input | 1 | Complex (I/Q pair) mode |
| iq_swap | input | 1 | Swap I and Q in complex mode |
| dds_data | input | 32 | Tone-synthesizer beat |
| pat_lo | input | 16 | Pattern word for slot 0 |
| pat_hi | input | 16 | Pattern word for slot 1 |
| dma_data | input | 32 | User data beat |
| lb_data | input | 32 | Loopback beat |
| out_valid | output | 1 | Registered beat valid |
| out_data | output | 32 | Registered channel beat |

## Verification
Some behaviours are checked by assertions on every cycle:
- the one-cycle valid delay;
- data hold while no beat is taken;
- the PRBS register never reaching zero and staying frozen while idle;
- the loopback override beating a programmed code, with and without offset conversion;
- the two overrides cancelling into the programmed code.

Other behaviours can only be shown by the bench's sweep. These are the full code map with its zero fill, the PN override, the I/Q swap and its dependence on complex mode, and the exact PRBS sequence. The sweep covers every select code under every override, format and swap combination, and compares each result with an arithmetic model.

// File: rtl/dac_src_pkg.sv
package dac_src_pkg;
    localparam logic [3:0] CODE_DDS  = 4'h0;
    localparam logic [3:0] CODE_PAT  = 4'h1;
    localparam logic [3:0] CODE_DMA  = 4'h2;
    localparam logic [3:0] CODE_LOOP = 4'h8;
    localparam logic [3:0] CODE_PRBS = 4'h9;
    localparam int PRBS_LEN = 15;
endpackage

// File: rtl/dac_src_resolve.sv
module dac_src_resolve
    import dac_src_pkg::*;
(
    input  logic [3:0] sel,
    input  logic       lb_ovr,
    input  logic       pn_ovr,
    output logic [3:0] eff_sel
);
    always_comb begin
        unique case ({lb_ovr, pn_ovr})
            2'b10:   eff_sel = CODE_LOOP;   // R4
            2'b01:   eff_sel = CODE_PRBS;   // R5
            default: eff_sel = sel;         // R6: both set cancel
        endcase
    end
endmodule

// File: rtl/dac_prbs_gen.sv
module dac_prbs_gen
    import dac_src_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [SW-1:0] sample
);
    localparam int PAD = SW - PRBS_LEN;

    logic [PRBS_LEN-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q;
        if (step) lfsr_d = {lfsr_q[PRBS_LEN-2:0], lfsr_q[PRBS_LEN-1] ^ lfsr_q[PRBS_LEN-2]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= '1;
        else        lfsr_q <= lfsr_d;
    end

    assign sample = {{PAD{1'b0}}, lfsr_q};

    AST_PRBS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0) else $error("prbs zero"); // R9
    AST_PRBS_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(lfsr_q)) else $error("prbs moved while idle"); // R9
endmodule

// File: rtl/dac_src_mux.sv
module dac_src_mux
    import dac_src_pkg::*;
#(
    parameter int SW = 16,
    parameter int BW = 2 * SW
) (
    input  logic [3:0]    eff_sel,
    input  logic [BW-1:0] dds_data,
    input  logic [SW-1:0] pat_lo,
    input  logic [SW-1:0] pat_hi,
    input  logic [BW-1:0] dma_data,
    input  logic [BW-1:0] lb_data,
    input  logic [SW-1:0] prbs_sample,
    output logic [BW-1:0] raw
);
    always_comb begin
        unique case (eff_sel)
            CODE_DDS:  raw = dds_data;
            CODE_PAT:  raw = {pat_hi, pat_lo};
            CODE_DMA:  raw = dma_data;
            CODE_LOOP: raw = lb_data;
            CODE_PRBS: raw = {prbs_sample, prbs_sample};
            default:   raw = '0;           // R3
        endcase
    end
endmodule

// File: rtl/dac_out_fmt.sv
module dac_out_fmt #(
    parameter int SW = 16,
    parameter int NSLOT = 2,
    parameter int BW = NSLOT * SW
) (
    input  logic [BW-1:0] raw,
    input  logic          fmt_offset,
    input  logic          iq_mode,
    input  logic          iq_swap,
    output logic [BW-1:0] fmt
);
    logic [BW-1:0] conv;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_comb begin
            conv[g*SW +: SW] = raw[g*SW +: SW];
            if (fmt_offset) conv[g*SW+SW-1] = ~raw[g*SW+SW-1];   // R7
        end
    end

    always_comb begin
        if (iq_mode && iq_swap) fmt = {conv[SW-1:0], conv[BW-1:SW]};  // R8
        else                    fmt = conv;
    end
endmodule

// File: rtl/dac_src_sel.sv
module dac_src_sel
    import dac_src_pkg::*;
#(
    parameter int SW = 16,
    localparam int BW = 2 * SW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    src_sel,
    input  logic          lb_ovr,
    input  logic          pn_ovr,
    input  logic          fmt_offset,
    input  logic          iq_mode,
    input  logic          iq_swap,
    input  logic [BW-1:0] dds_data,
    input  logic [SW-1:0] pat_lo,
    input  logic [SW-1:0] pat_hi,
    input  logic [BW-1:0] dma_data,
    input  logic [BW-1:0] lb_data,
    output logic          out_valid,
    output logic [BW-1:0] out_data
);
    localparam logic [BW-1:0] MSB_MASK = {1'b1, {(SW-1){1'b0}}, 1'b1, {(SW-1){1'b0}}};

    typedef struct packed {
        logic          valid;
        logic [BW-1:0] data;
    } out_reg_t;

    out_reg_t      st_d, st_q;
    logic [3:0]    eff_sel;
    logic [SW-1:0] prbs_sample;
    logic [BW-1:0] raw, fmt;

    dac_src_resolve u_resolve (
        .sel(src_sel), .lb_ovr(lb_ovr), .pn_ovr(pn_ovr), .eff_sel(eff_sel)
    );

    dac_prbs_gen #(.SW(SW)) u_prbs (
        .clk(clk), .rst_n(rst_n), .step(in_valid), .sample(prbs_sample)
    );

    dac_src_mux #(.SW(SW), .BW(BW)) u_mux (
        .eff_sel(eff_sel), .dds_data(dds_data), .pat_lo(pat_lo), .pat_hi(pat_hi),
        .dma_data(dma_data), .lb_data(lb_data), .prbs_sample(prbs_sample), .raw(raw)
    );

    dac_out_fmt #(.SW(SW), .NSLOT(2), .BW(BW)) u_fmt (
        .raw(raw), .fmt_offset(fmt_offset), .iq_mode(iq_mode), .iq_swap(iq_swap), .fmt(fmt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) st_d.data = fmt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_data  = st_q.data;

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid)) else $error("valid delay"); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data)) else $error("data moved while idle"); // R10
    AST_LB_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && lb_ovr && !pn_ovr && !fmt_offset && !(iq_mode && iq_swap)
        |=> out_data == $past(lb_data)) else $error("loopback override"); // R4
    AST_LB_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && lb_ovr && !pn_ovr && fmt_offset && !(iq_mode && iq_swap)
        |=> out_data == ($past(lb_data) ^ MSB_MASK)) else $error("offset binary"); // R7
    AST_BOTH_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && lb_ovr && pn_ovr && src_sel == CODE_DMA && !fmt_offset && !(iq_mode && iq_swap)
        |=> out_data == $past(dma_data)) else $error("override cancel"); // R6
endmodule

// File: tb/sim_dac_src_sel.sv
module sim_dac_src_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  src_sel = '0;
    logic        lb_ovr = 1'b0, pn_ovr = 1'b0, fmt_offset = 1'b0, iq_mode = 1'b0, iq_swap = 1'b0;
    logic [31:0] dds_data = '0, dma_data = '0, lb_data = '0;
    logic [15:0] pat_lo = '0, pat_hi = '0;
    logic        out_valid;
    logic [31:0] out_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [14:0] model_prbs = 15'h7FFF;

    always #2 clk = ~clk;

    dac_src_sel u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_sel(src_sel),
        .lb_ovr(lb_ovr), .pn_ovr(pn_ovr), .fmt_offset(fmt_offset),
        .iq_mode(iq_mode), .iq_swap(iq_swap), .dds_data(dds_data),
        .pat_lo(pat_lo), .pat_hi(pat_hi), .dma_data(dma_data), .lb_data(lb_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [14:0] p);
        logic [3:0]  eff;
        logic [31:0] r;
        if (lb_ovr && !pn_ovr)      eff = 4'h8;
        else if (pn_ovr && !lb_ovr) eff = 4'h9;
        else                        eff = src_sel;
        case (eff)
            4'h0: r = dds_data;
            4'h1: r = {pat_hi, pat_lo};
            4'h2: r = dma_data;
            4'h8: r = lb_data;
            4'h9: r = {1'b0, p, 1'b0, p};
            default: r = 32'h0;
        endcase
        if (fmt_offset) r = r ^ 32'h8000_8000;
        if (iq_mode && iq_swap) r = {r[15:0], r[31:16]};
        return r;
    endfunction

    function automatic string tag_of();
        if (fmt_offset) return "R7";
        if (iq_swap) return "R8";
        if (lb_ovr && pn_ovr) return "R6";
        if (lb_ovr) return "R4";
        if (pn_ovr) return "R5";
        if (src_sel == 4'h9) return "R9";
        if (src_sel inside {4'h0, 4'h1, 4'h2, 4'h8}) return "R2";
        return "R3";
    endfunction

    // Drive one valid beat (called at a negedge), check after the next edge.
    task automatic beat();
        logic [31:0] exp;
        string t;
        in_valid = 1'b1;
        exp = model(model_prbs);
        t = tag_of();
        @(negedge clk);
        check("R10", {31'b0, out_valid}, 32'h1);
        check(t, out_data, exp);
        model_prbs = {model_prbs[13:0], model_prbs[14] ^ model_prbs[13]};
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", {31'b0, out_valid}, 32'h0);
        check("R1", out_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // First PRBS beat after reset shows the seed.
        src_sel = 4'h9;
        beat();
        check("R1", out_data, 32'h7FFF_7FFF);
        // Sweep every code under every control combination.
        for (int i = 0; i < 512; i++) begin
            src_sel    = i[3:0];
            lb_ovr     = i[4];
            pn_ovr     = i[5];
            fmt_offset = i[6];
            iq_mode    = i[7];
            iq_swap    = i[8];
            dds_data   = 32'h1357_9BDF ^ (i * 32'h9E37_79B1);
            dma_data   = 32'hA5C3_0F96 + (i * 32'h0101_0707);
            lb_data    = ~(i * 32'h0F0F_3331);
            pat_lo     = 16'hC001 ^ i[15:0];
            pat_hi     = 16'h7E11 + i[15:0];
            beat();
        end
        // Idle beats: output held, PRBS frozen.
        begin
            logic [31:0] held;
            held = out_data;
            in_valid = 1'b0;
            src_sel = 4'h0; lb_ovr = 0; pn_ovr = 0; fmt_offset = 1; iq_mode = 1; iq_swap = 1;
            dds_data = ~held;
            repeat (3) begin
                @(negedge clk);
                check("R10", {31'b0, out_valid}, 32'h0);
                check("R10", out_data, held);
            end
        end
        fmt_offset = 0; iq_mode = 0; iq_swap = 0; pn_ovr = 1;
        beat();
        beat();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule